// File: doc/BRIEF.md
# Serially Configured Four-Input Logic Cell

This block is one programmable logic element. Its behaviour is set entirely by a configuration word of twenty bits that is shifted in one bit per configuration clock while the configuration enable is high. Sixteen of those bits form a one-bit-wide truth table. The four logic inputs select one entry of that table. The remaining four bits choose how the result reaches the output: either straight through, or via a storage flip-flop. That flip-flop has a programmable start value and a programmable synchronous set/reset driven by a user pin.

The chain's outgoing end is brought out as a pin, so several cells can be daisy-chained and loaded from one serial stream. Configuration storage is volatile. Reset clears it to all zeros, and the cell must be loaded again before it does useful work. While loading is in progress the cell output is held low.

Top module: `lut_cell`

## Requirements
- R1: With configuration enable low and the register-mode bit clear, `cell_out` equals the table entry addressed by `lin`, where `lin[0]` is the least significant address bit.
- R2: Stream bit k (k counted from the first bit shifted) sets table address k for k = 0..15. Bit 16 is the register-mode enable, bit 17 the set/reset active level, bit 18 the set/reset target value, and bit 19 the flip-flop start value.
- R3: The configuration chain moves by one position on a `cfg_clk` rising edge only while `cfg_en` is high. Otherwise it keeps its contents, whatever `cfg_din` does.
- R4: `cfg_dout` shows the chain bit that leaves on the next shift. After exactly 20 shifts it equals stream bit 0, and after one further shift it equals stream bit 1.
- R5: While `cfg_en` is high, `cell_out` is 0.
- R6: In register mode, `cell_out` is the flip-flop. The flip-flop captures the table output on a `user_clk` rising edge when `ce` is high, and a change of `lin` between edges does not reach `cell_out`.
- R7: In register mode, with `ce` low and set/reset inactive, the flip-flop keeps its value across user clock edges.
- R8: The flip-flop loads the start value on every user clock edge while `cfg_en` is high, and on the first user clock edge after `cfg_en` falls.
- R9: When `sr_in` equals the configured active level, the next user clock edge loads the configured target value. This happens regardless of `ce` and takes priority over table data.
- R10: Asserting `rst_n` low clears the whole configuration to zeros at once, so `cell_out` and `cfg_dout` are 0 until the cell is loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each clock domain |
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_en | input | 1 | Configuration enable; shifting happens only while it is high |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out, for cascading |
| user_clk | input | 1 | Clock of the output flip-flop |
| ce | input | 1 | Clock enable of the output flip-flop |
| sr_in | input | 1 | Synchronous set/reset request, active level configurable |
| lin | input | 4 | Logic inputs, table address |
| cell_out | output | 1 | Cell output |

## Verification
Several truth tables are loaded, each with a single hot entry or a full parity pattern, so that a design that reversed the stream order or the address bits would show a wrong value at a known input. Registered mode is exercised so that a flip-flop that ignored `ce`, let `lin` through between edges, or skipped the start-value reload after configuration would be caught on a particular edge. Set/reset is tested at both active levels and both target values, with `ce` low and against opposing table data, which exposes a reversed polarity or a set/reset gated by `ce`. The chain is also shown to hold still while `cfg_en` is low, to appear correctly at `cfg_dout`, and to clear immediately on reset.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

  // Mode field of the configuration word, most significant bit first.
  typedef struct packed {
    logic init_val;   // stream bit 19
    logic sr_target;  // stream bit 18
    logic sr_level;   // stream bit 17
    logic reg_mode;   // stream bit 16
  } cell_mode_t;

  localparam int unsigned MODE_W = $bits(cell_mode_t);

endpackage

// File: rtl/lut_rst_sync.sv
module lut_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/lut_cfg_chain.sv
module lut_cfg_chain #(
  parameter int unsigned CHAIN_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               din,
  output logic [CHAIN_W-1:0] chain,
  output logic               dout
);

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  // New bits enter at the top and walk toward bit 0.
  always_comb begin
    chain_d = chain_q;
    if (shift_en) chain_d = {din, chain_q[CHAIN_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign chain = chain_q;
  assign dout  = chain_q[0];

endmodule

// File: rtl/lut_table_mux.sv
module lut_table_mux #(
  parameter int unsigned K = 4,
  localparam int unsigned DEPTH = 1 << K
) (
  input  logic [DEPTH-1:0] table_bits,
  input  logic [K-1:0]     addr,
  output logic             dout
);

  // Binary mux tree, one generate level per address bit.
  for (genvar lv = 0; lv <= K; lv++) begin : g_lvl
    logic [(DEPTH >> lv)-1:0] node;
    if (lv == 0) begin : g_leaf
      assign node = table_bits;
    end else begin : g_mux
      for (genvar n = 0; n < (DEPTH >> lv); n++) begin : g_n
        assign node[n] = addr[lv-1] ? g_lvl[lv-1].node[2*n+1]
                                    : g_lvl[lv-1].node[2*n];
      end
    end
  end

  assign dout = g_lvl[K].node[0];

endmodule

// File: rtl/lut_out_reg.sv
module lut_out_reg
  import lut_cell_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_busy,
  input  logic       d,
  input  logic       ce,
  input  logic       sr_in,
  input  cell_mode_t mode,
  output logic       q
);

  logic q_q, q_d;
  logic busy_q;
  logic sr_act;

  assign sr_act = (sr_in == mode.sr_level);

  always_comb begin
    q_d = q_q;
    if (cfg_busy || busy_q)          q_d = mode.init_val;
    else if (mode.reg_mode && sr_act) q_d = mode.sr_target;
    else if (ce)                     q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      q_q    <= q_d;
      busy_q <= cfg_busy;
    end
  end

  assign q = q_q;

endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
#(
  parameter int unsigned LUT_K       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             rst_n,
  input  logic             cfg_clk,
  input  logic             cfg_en,
  input  logic             cfg_din,
  output logic             cfg_dout,
  input  logic             user_clk,
  input  logic             ce,
  input  logic             sr_in,
  input  logic [LUT_K-1:0] lin,
  output logic             cell_out
);

  localparam int unsigned DEPTH   = 1 << LUT_K;
  localparam int unsigned CHAIN_W = DEPTH + MODE_W;

  logic               cfg_rst_n;
  logic               usr_rst_n;
  logic [CHAIN_W-1:0] chain_q;
  cell_mode_t         mode;
  logic               lut_o;
  logic               reg_q;

  lut_rst_sync #(.STAGES(SYNC_STAGES)) i_cfg_rst (
    .clk(cfg_clk), .arst_n(rst_n), .srst_n(cfg_rst_n)
  );

  lut_rst_sync #(.STAGES(SYNC_STAGES)) i_usr_rst (
    .clk(user_clk), .arst_n(rst_n), .srst_n(usr_rst_n)
  );

  lut_cfg_chain #(.CHAIN_W(CHAIN_W)) i_chain (
    .clk(cfg_clk), .rst_n(cfg_rst_n), .shift_en(cfg_en),
    .din(cfg_din), .chain(chain_q), .dout(cfg_dout)
  );

  assign mode = cell_mode_t'(chain_q[CHAIN_W-1:DEPTH]);

  lut_table_mux #(.K(LUT_K)) i_mux (
    .table_bits(chain_q[DEPTH-1:0]), .addr(lin), .dout(lut_o)
  );

  lut_out_reg i_oreg (
    .clk(user_clk), .rst_n(usr_rst_n), .cfg_busy(cfg_en), .d(lut_o),
    .ce(ce), .sr_in(sr_in), .mode(mode), .q(reg_q)
  );

  always_comb begin
    if (cfg_en)             cell_out = 1'b0;
    else if (mode.reg_mode) cell_out = reg_q;
    else                    cell_out = lut_o;
  end

endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk
  import lut_cell_pkg::*;
#(
  parameter int unsigned CHAIN_W = 20
) (
  input logic               cfg_clk,
  input logic               user_clk,
  input logic               crst_n,
  input logic               urst_n,
  input logic               cfg_en,
  input logic               cfg_din,
  input logic               cfg_dout,
  input logic [CHAIN_W-1:0] chain,
  input cell_mode_t         mode,
  input logic               ce,
  input logic               sr_in,
  input logic               q,
  input logic               cell_out
);

  logic sr_act;
  assign sr_act = (sr_in == mode.sr_level);

  a_r3_shift_in: assert property (@(posedge cfg_clk) disable iff (!crst_n)
    cfg_en |=> chain[CHAIN_W-1] == $past(cfg_din));

  a_r3_hold: assert property (@(posedge cfg_clk) disable iff (!crst_n)
    !cfg_en |=> $stable(chain));

  a_r4_dout_next: assert property (@(posedge cfg_clk) disable iff (!crst_n)
    cfg_en |=> cfg_dout == $past(chain[1]));

  a_r5_busy_low: assert property (@(posedge user_clk) disable iff (!urst_n)
    cfg_en |-> !cell_out);

  a_r6_reg_out: assert property (@(posedge user_clk) disable iff (!urst_n)
    (!cfg_en && mode.reg_mode) |-> cell_out == q);

  a_r7_ce_hold: assert property (@(posedge user_clk) disable iff (!urst_n)
    (mode.reg_mode && !ce && !sr_act && !cfg_en && !$past(cfg_en)) |=> $stable(q));

  a_r9_sr_wins: assert property (@(posedge user_clk) disable iff (!urst_n)
    (mode.reg_mode && sr_act && !cfg_en && !$past(cfg_en)) |=> q == $past(mode.sr_target));

endmodule

bind lut_cell lut_cell_chk #(.CHAIN_W(CHAIN_W)) i_lut_cell_chk (
  .cfg_clk(cfg_clk), .user_clk(user_clk), .crst_n(cfg_rst_n), .urst_n(usr_rst_n),
  .cfg_en(cfg_en), .cfg_din(cfg_din), .cfg_dout(cfg_dout), .chain(chain_q),
  .mode(mode), .ce(ce), .sr_in(sr_in), .q(reg_q), .cell_out(cell_out)
);

// File: tb/test_lut_cell.sv
module test_lut_cell;

  logic       clk = 1'b0;
  logic       rst_n, cfg_en, cfg_din, ce, sr_in;
  logic [3:0] lin;
  logic       cfg_dout, cell_out;
  int         errors = 0;
  int         checks = 0;
  bit         done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  lut_cell i_lut_cell (
    .rst_n(rst_n), .cfg_clk(clk), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .cfg_dout(cfg_dout), .user_clk(clk), .ce(ce), .sr_in(sr_in),
    .lin(lin), .cell_out(cell_out)
  );

  // {table, lin, expected}, combinational mode (R1, R2)
  localparam logic [20:0] VEC [8] = '{
    {16'h8000, 4'hF, 1'b1}, {16'h8000, 4'h7, 1'b0},
    {16'h6996, 4'h1, 1'b1}, {16'h6996, 4'h3, 1'b0},
    {16'hFFFE, 4'h0, 1'b0}, {16'hFFFE, 4'h8, 1'b1},
    {16'h0020, 4'h5, 1'b1}, {16'h0020, 4'h4, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  // word bit k is shifted k-th: [15:0] table, 16 reg, 17 level, 18 target, 19 init
  task automatic load(input logic [19:0] w);
    cfg_en = 1'b1;
    for (int k = 0; k < 20; k++) begin
      cfg_din = w[k];
      tick();
      if (k == 10) chk("R5 low while loading", cell_out, 1'b0);
    end
    cfg_en = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_en = 1'b0; cfg_din = 1'b0; ce = 1'b0; sr_in = 1'b0; lin = '0;
    #1;
    chk("R10 reset out", cell_out, 1'b0);
    chk("R10 reset dout", cfg_dout, 1'b0);
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1/R2 vector walk
    foreach (VEC[i]) begin
      load({4'b0000, VEC[i][20:5]});
      lin = VEC[i][4:1]; #1;
      chk("R1 lookup", cell_out, VEC[i][0]);
    end

    // R3 / R4: hold while disabled, then one more shift
    load({4'b0000, 16'h0022});
    lin = 4'h5; #1;
    chk("R4 dout after 20", cfg_dout, 1'b0);
    for (int k = 0; k < 5; k++) begin cfg_din = k[0]; tick(); end
    chk("R3 table kept", cell_out, 1'b1);
    chk("R3 dout kept", cfg_dout, 1'b0);
    cfg_en = 1'b1; cfg_din = 1'b0; tick(); cfg_en = 1'b0;
    chk("R4 dout second bit", cfg_dout, 1'b1);

    // R6/R7/R8: init=1, reg mode, level=1 (sr_in 0 inactive), table addr1 only
    lin = 4'h0; ce = 1'b0; sr_in = 1'b0;
    load({1'b1, 1'b0, 1'b1, 1'b1, 16'h0002});
    tick();
    chk("R8 init after config", cell_out, 1'b1);
    tick();
    chk("R7 ce low holds", cell_out, 1'b1);
    ce = 1'b1; tick();
    chk("R6 captures table 0", cell_out, 1'b0);
    lin = 4'h1; #1;
    chk("R6 no pass-through", cell_out, 1'b0);
    tick();
    chk("R6 captures table 1", cell_out, 1'b1);

    // R9: active-high set, ce low, table zero
    ce = 1'b0; sr_in = 1'b0;
    load({1'b0, 1'b1, 1'b1, 1'b1, 16'h0000});
    tick();
    chk("R8 init zero", cell_out, 1'b0);
    sr_in = 1'b1; tick();
    chk("R9 set ignores ce", cell_out, 1'b1);
    sr_in = 1'b0; ce = 1'b1; tick();
    chk("R9 release to data", cell_out, 1'b0);

    // R9: active-low reset vs table ones
    sr_in = 1'b1; ce = 1'b0;
    load({1'b0, 1'b0, 1'b0, 1'b1, 16'hFFFF});
    tick();
    ce = 1'b1; tick();
    chk("R9 inactive high lets data", cell_out, 1'b1);
    sr_in = 1'b0; tick();
    chk("R9 low level resets", cell_out, 1'b0);
    sr_in = 1'b1; tick();
    chk("R9 data returns", cell_out, 1'b1);

    // R10: reset wipes configuration
    ce = 1'b0;
    load({4'b0000, 16'hFFFF});
    lin = 4'h3; #1;
    chk("R1 all ones", cell_out, 1'b1);
    rst_n = 1'b0; #1;
    chk("R10 cleared out", cell_out, 1'b0);
    chk("R10 cleared dout", cfg_dout, 1'b0);
    repeat (2) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R10 stays empty", cell_out, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule